// File: doc/BRIEF.md
# Address-Folded SECDED Read Checker

This block sits on the read path of a nonvolatile memory array. Every stored word carries eight check bits. These bits were computed over the data word and over the address it was written to. On a read, the checker recomputes the code from the raw data and from the address that was actually requested. It then compares the result with the stored check bits. A row or column decoder that lands on the wrong location therefore shows up as a nonzero syndrome, in the same way as a flipped data cell.

A single flipped data bit is repaired in the returned word in the same cycle, and a one-cycle correctable pulse is raised. A double error, or a syndrome that points at an address bit, is treated as uncorrectable. In that case the block asks the processor for a data abort and records the faulting address. It also drives an active-low error pin that stays low until software clears the fault log. Only the first uncorrectable address is held. Later ones set an overflow flag. A matching encoder module computes the check bits for programming.

Top module: `adsec_read_checker`

## Requirements
- R1: A read of a word whose check bits match its data and address raises neither pulse, and it returns the data unchanged.
- R2: When exactly one data bit of a read differs from the encoded word, the returned data is the original word in the same cycle. `sec_pulse` is high for that read and `abort_req` stays low.
- R3: When exactly one of the eight stored check bits is flipped, the read raises `sec_pulse` with no abort, and the data passes unchanged.
- R4: When the requested address differs in exactly one bit from the address used at encoding, the read raises `ded_pulse` and `abort_req` in the same cycle, and `sec_pulse` stays low.
- R5: Any two flipped bits among data, address and check bits raise `ded_pulse` and `abort_req`, and `sec_pulse` stays low.
- R6: On an uncorrectable read while the log is empty, `fault_addr` takes the requested address and `fault_valid` goes high on the next clock edge. Both then hold until they are cleared. After reset both are zero.
- R7: An uncorrectable read while `fault_valid` is already high sets `fault_ovf` on the next edge and leaves `fault_addr` unchanged.
- R8: `err_n` is high after reset. It goes low on the edge after an uncorrectable read and stays low until it is cleared.
- R9: `clr_fault` zeroes `fault_addr`, `fault_valid` and `fault_ovf`, and releases `err_n` high, on the next edge. If an uncorrectable read falls in the same cycle, that read is logged as a new first fault: valid high, its address captured, overflow low and `err_n` low.
- R10: While `rd_valid` is low, `sec_pulse`, `ded_pulse` and `abort_req` are low whatever the other inputs carry.
- R11: For any input, including words with three or more flipped bits, `sec_pulse` and `ded_pulse` are never high together. No particular class is promised for three or more flips.
- R12: Code layout. The message is {address, data}, with data in message bits 0..63 and address in bits 64..85. Message bit k sits at the k-th integer, counting from 3 upwards, that is not a power of two. Check bit j (j = 0..6) is the XOR of the message bits whose position has bit j set. Check bit 7 is the XOR of all message bits and check bits 0..6. The encoder produces exactly these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_addr | input | 22 | Requested address |
| rd_data | input | 64 | Raw data word from the array |
| rd_chk | input | 8 | Stored check bits from the array |
| clr_fault | input | 1 | Software clear of the fault log and error pin |
| out_data | output | 64 | Corrected data, same cycle |
| sec_pulse | output | 1 | Correctable error on this read |
| ded_pulse | output | 1 | Uncorrectable error on this read |
| abort_req | output | 1 | Data abort request to the processor |
| fault_addr | output | 22 | First uncorrectable address |
| fault_valid | output | 1 | Fault address is held |
| fault_ovf | output | 1 | A further uncorrectable read came while the log was full |
| err_n | output | 1 | Latched active-low error pin |

## Verification
Two functions can fall in the same cycle: the software clear of the fault log and the capture of a new uncorrectable read. The bench deliberately asserts `clr_fault` in the same cycle as an address-flipped read while the log is full and overflowed. It expects the new address to be captured as a first fault, with overflow cleared and the pin kept low. It also runs a clear with no error beside it, and random pair flips with periodic clears. A bench model of the log judges every registered output one edge later.

// File: rtl/adsec_pkg.sv
package adsec_pkg;

    // Smallest Hamming width r that covers msg_w message bits plus r check bits.
    function automatic int ham_bits(input int msg_w);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= msg_w + r + 1) return r;
        end
        return 31;
    endfunction

    // Code position of message bit k: the k-th integer >= 3 that is not a power of two.
    function automatic int code_pos(input int k);
        int p;
        p = k + 1;
        for (int j = 0; j < 31; j++) begin
            if ((1 << j) <= p) p = p + 1;
        end
        return p;
    endfunction

endpackage

// File: rtl/adsec_encoder.sv
module adsec_encoder #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 22,
    localparam int MSG_W = DATA_W + ADDR_W,
    localparam int HAM_W = adsec_pkg::ham_bits(MSG_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [MSG_W-1:0] msg;
    logic [HAM_W-1:0] contrib [MSG_W];
    logic [HAM_W-1:0] ham;

    assign msg = {addr_i, data_i};

    for (genvar i = 0; i < MSG_W; i++) begin : g_pos
        localparam int POS = adsec_pkg::code_pos(i);
        localparam logic [HAM_W-1:0] POS_V = POS[HAM_W-1:0];
        assign contrib[i] = msg[i] ? POS_V : '0;
    end

    always_comb begin
        ham = '0;
        for (int i = 0; i < MSG_W; i++) begin
            ham = ham ^ contrib[i];
        end
    end

    assign chk_o = {(^msg) ^ (^ham), ham};

endmodule

// File: rtl/adsec_syndrome_decode.sv
module adsec_syndrome_decode #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 22,
    localparam int MSG_W = DATA_W + ADDR_W,
    localparam int HAM_W = adsec_pkg::ham_bits(MSG_W),
    localparam int CHK_W = HAM_W + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              uncorr_o
);

    logic [CHK_W-1:0]  recalc;
    logic [HAM_W-1:0]  syn;
    logic              ovr;
    logic [DATA_W-1:0] data_hit;

    adsec_encoder #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) recode_i (
        .addr_i(addr_i),
        .data_i(data_i),
        .chk_o (recalc)
    );

    assign syn = chk_i[HAM_W-1:0] ^ recalc[HAM_W-1:0];
    assign ovr = chk_i[HAM_W] ^ recalc[HAM_W] ^ (^syn);

    // Only data positions can be repaired; a syndrome at an address position is a decode fault.
    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam int POS = adsec_pkg::code_pos(i);
        localparam logic [HAM_W-1:0] POS_V = POS[HAM_W-1:0];
        assign data_hit[i] = (syn == POS_V);
    end

    always_comb begin
        data_o   = data_i;
        single_o = 1'b0;
        uncorr_o = 1'b0;
        if (ovr) begin
            if (syn == '0 || $onehot(syn)) begin
                single_o = 1'b1;
            end else if (|data_hit) begin
                single_o = 1'b1;
                data_o   = data_i ^ data_hit;
            end else begin
                uncorr_o = 1'b1;
            end
        end else if (syn != '0) begin
            uncorr_o = 1'b1;
        end
    end

endmodule

// File: rtl/adsec_read_checker.sv
module adsec_read_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 22,
    localparam int CHK_W = adsec_pkg::ham_bits(DATA_W + ADDR_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic              clr_fault,
    output logic [DATA_W-1:0] out_data,
    output logic              sec_pulse,
    output logic              ded_pulse,
    output logic              abort_req,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_valid,
    output logic              fault_ovf,
    output logic              err_n
);

    typedef struct packed {
        logic [ADDR_W-1:0] faddr;
        logic              fvalid;
        logic              ovf;
        logic              err;
    } log_t;

    log_t state_d, state_q;
    logic single_w, uncorr_w;

    adsec_syndrome_decode #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) dec_i (
        .addr_i  (rd_addr),
        .data_i  (rd_data),
        .chk_i   (rd_chk),
        .data_o  (out_data),
        .single_o(single_w),
        .uncorr_o(uncorr_w)
    );

    assign sec_pulse = rd_valid & single_w;
    assign ded_pulse = rd_valid & uncorr_w;
    assign abort_req = ded_pulse;

    always_comb begin
        state_d = state_q;
        if (clr_fault) begin
            state_d.faddr  = '0;
            state_d.fvalid = 1'b0;
            state_d.ovf    = 1'b0;
            state_d.err    = 1'b0;
        end
        if (ded_pulse) begin
            state_d.err = 1'b1;
            if (!state_d.fvalid) begin
                state_d.faddr  = rd_addr;
                state_d.fvalid = 1'b1;
            end else begin
                state_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_addr  = state_q.faddr;
    assign fault_valid = state_q.fvalid;
    assign fault_ovf   = state_q.ovf;
    assign err_n       = ~state_q.err;

endmodule

// File: rtl/adsec_read_checker_sva.sv
module adsec_read_checker_sva #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 22,
    localparam int CHK_W = adsec_pkg::ham_bits(DATA_W + ADDR_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHK_W-1:0]  rd_chk,
    input logic              clr_fault,
    input logic [DATA_W-1:0] out_data,
    input logic              sec_pulse,
    input logic              ded_pulse,
    input logic              abort_req,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              fault_valid,
    input logic              fault_ovf,
    input logic              err_n
);

    // A clean word must come back untouched (R1).
    assert_clean_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !sec_pulse && !ded_pulse) |-> (out_data == rd_data))
        else $error("R1 data altered on a clean read");

    assert_sec_no_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> !abort_req)
        else $error("R2 abort with a correctable error");

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_pulse && ded_pulse))
        else $error("R11 both pulses high");

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!sec_pulse && !ded_pulse && !abort_req))
        else $error("R10 pulse without a read");

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_pulse && (!fault_valid || clr_fault)) |=> (fault_valid && fault_addr == $past(rd_addr)))
        else $error("R6 fault address not captured");

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !clr_fault) |=> (fault_valid && $stable(fault_addr)))
        else $error("R6 fault address not held");

    assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_valid) |-> $past(ded_pulse))
        else $error("R6 log filled without an error");

    assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_pulse && fault_valid && !clr_fault) |=> fault_ovf)
        else $error("R7 overflow not flagged");

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ded_pulse |=> !err_n)
        else $error("R8 error pin not asserted");

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && !clr_fault) |=> !err_n)
        else $error("R8 error pin released without clear");

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fault && !ded_pulse) |=> (err_n && !fault_valid && !fault_ovf && fault_addr == '0))
        else $error("R9 clear not applied");

endmodule

bind adsec_read_checker adsec_read_checker_sva #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_chk     (rd_chk),
    .clr_fault  (clr_fault),
    .out_data   (out_data),
    .sec_pulse  (sec_pulse),
    .ded_pulse  (ded_pulse),
    .abort_req  (abort_req),
    .fault_addr (fault_addr),
    .fault_valid(fault_valid),
    .fault_ovf  (fault_ovf),
    .err_n      (err_n)
);

// File: tb/adsec_read_checker_tb_top.sv
`timescale 1ns/1ps
module adsec_read_checker_tb_top;

    localparam int DW = 64;
    localparam int AW = 22;
    localparam int CW = 8;
    localparam int NPOS = DW + AW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data = '0;
    logic [CW-1:0] rd_chk = '0;
    logic          clr_fault = 1'b0;
    logic [DW-1:0] out_data;
    logic          sec_pulse, ded_pulse, abort_req;
    logic [AW-1:0] fault_addr;
    logic          fault_valid, fault_ovf, err_n;

    logic [AW-1:0] enc_addr = '0;
    logic [DW-1:0] enc_data = '0;
    logic [CW-1:0] enc_chk;

    int checks = 0;
    int errors = 0;

    // bench model of the fault log
    logic [AW-1:0] m_fa = '0;
    logic          m_fv = 1'b0;
    logic          m_ovf = 1'b0;
    logic          m_err = 1'b0;

    always #2 clk = ~clk;

    adsec_read_checker #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_chk(rd_chk), .clr_fault(clr_fault),
        .out_data(out_data), .sec_pulse(sec_pulse), .ded_pulse(ded_pulse),
        .abort_req(abort_req), .fault_addr(fault_addr), .fault_valid(fault_valid),
        .fault_ovf(fault_ovf), .err_n(err_n)
    );

    adsec_encoder #(.DATA_W(DW), .ADDR_W(AW)) enc_i (
        .addr_i(enc_addr), .data_i(enc_data), .chk_o(enc_chk)
    );

    function automatic logic [CW-1:0] tb_encode(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW+AW-1:0] m;
        logic [6:0] s;
        int k;
        m = {a, d};
        s = '0;
        k = 0;
        for (int p = 1; p < 128; p++) begin
            if (((p & (p - 1)) != 0) && k < DW + AW) begin
                if (m[k]) s = s ^ p[6:0];
                k++;
            end
        end
        return {(^m) ^ (^s), s};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_log(input string req);
        check(fault_valid == m_fv, {req, " fault_valid"}, 64'(fault_valid), 64'(m_fv));
        check(fault_ovf == m_ovf, {req, " fault_ovf"}, 64'(fault_ovf), 64'(m_ovf));
        check(err_n == !m_err, {req, " err_n"}, 64'(err_n), 64'(!m_err));
        check(fault_addr == m_fa, {req, " fault_addr"}, 64'(fault_addr), 64'(m_fa));
    endtask

    // kind: 0 clean, 1 correctable, 2 uncorrectable, 3 three or more flips
    task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [CW-1:0] c, input logic clr, input int kind,
                        input logic [DW-1:0] exp_d, input string req);
        logic ded_seen;
        @(negedge clk);
        rd_valid = v; rd_addr = a; rd_data = d; rd_chk = c; clr_fault = clr;
        #1;
        if (!v) begin
            check(!sec_pulse && !ded_pulse && !abort_req, {req, " quiet while idle"},
                  64'({sec_pulse, ded_pulse, abort_req}), 64'd0);
        end else if (kind == 3) begin
            check(!(sec_pulse && ded_pulse), {req, " exclusive pulses"},
                  64'({sec_pulse, ded_pulse}), 64'd0);
        end else begin
            check(sec_pulse == (kind == 1), {req, " sec_pulse"}, 64'(sec_pulse), 64'(kind == 1));
            check(ded_pulse == (kind == 2), {req, " ded_pulse"}, 64'(ded_pulse), 64'(kind == 2));
            check(abort_req == (kind == 2), {req, " abort_req"}, 64'(abort_req), 64'(kind == 2));
            if (kind < 2) check(out_data == exp_d, {req, " out_data"}, out_data, exp_d);
        end
        ded_seen = (kind == 3) ? (v && ded_pulse) : (v && kind == 2);
        if (clr) begin m_fa = '0; m_fv = 1'b0; m_ovf = 1'b0; m_err = 1'b0; end
        if (ded_seen) begin
            m_err = 1'b1;
            if (!m_fv) begin m_fa = a; m_fv = 1'b1; end else m_ovf = 1'b1;
        end
        @(posedge clk);
        #1;
        check_log(req);
    endtask

    // Flip n code positions (0..63 data, 64..85 address, 86..93 check) and read.
    task automatic flip_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n,
                             input int p0, input int p1, input int p2, input logic clr,
                             input string req);
        logic [AW-1:0] aa;
        logic [DW-1:0] dd;
        logic [CW-1:0] cc;
        int ps [3];
        int kind;
        aa = a; dd = d; cc = tb_encode(a, d);
        ps[0] = p0; ps[1] = p1; ps[2] = p2;
        for (int i = 0; i < n; i++) begin
            if (ps[i] < DW) dd[ps[i]] = ~dd[ps[i]];
            else if (ps[i] < DW + AW) aa[ps[i] - DW] = ~aa[ps[i] - DW];
            else cc[ps[i] - DW - AW] = ~cc[ps[i] - DW - AW];
        end
        if (n == 0) kind = 0;
        else if (n == 1) kind = (p0 >= DW && p0 < DW + AW) ? 2 : 1;
        else if (n == 2) kind = 2;
        else kind = 3;
        step(1'b1, aa, dd, cc, clr, kind, d, req);
    endtask

    function automatic logic [DW-1:0] rnd_data();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [AW-1:0] rnd_addr();
        return AW'($urandom());
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int q0, q1, q2;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1;
        check_log("R6 R8 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R12 encoder against the stated layout
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            enc_addr = (i == 0) ? '0 : rnd_addr();
            enc_data = (i == 1) ? '1 : rnd_data();
            #1;
            check(enc_chk == tb_encode(enc_addr, enc_data), "R12 encoder bits",
                  64'(enc_chk), 64'(tb_encode(enc_addr, enc_data)));
        end

        // R1 clean reads, including all-zero and all-one corners
        flip_read('0, '0, 0, 0, 0, 0, 1'b0, "R1 zero word");
        flip_read('1, '1, 0, 0, 0, 0, 1'b0, "R1 ones word");
        for (int i = 0; i < 20; i++) flip_read(rnd_addr(), rnd_data(), 0, 0, 0, 0, 1'b0, "R1 clean");

        // R10 garbage with no valid
        step(1'b0, rnd_addr(), rnd_data(), 8'h5a, 1'b0, 0, '0, "R10 idle garbage");

        // R2 every data position
        for (int i = 0; i < DW; i++) flip_read(rnd_addr(), rnd_data(), 1, i, 0, 0, 1'b0, "R2 data flip");
        // R3 every check position
        for (int i = 0; i < CW; i++) flip_read(rnd_addr(), rnd_data(), 1, DW + AW + i, 0, 0, 1'b0, "R3 check flip");

        // R4 every address position; first one is captured (R6), the rest overflow (R7)
        for (int i = 0; i < AW; i++) begin
            flip_read(rnd_addr(), rnd_data(), 1, DW + i, 0, 0, 1'b0,
                      (i == 0) ? "R4 R6 R8 address flip first" : "R4 R7 address flip again");
        end

        // R9 clear together with a new uncorrectable read: new first fault wins
        flip_read(22'h2aaaaa, rnd_data(), 1, DW + 3, 0, 0, 1'b1, "R9 clear with error");
        // R9 plain clear
        step(1'b0, '0, '0, '0, 1'b1, 0, '0, "R9 clear alone");
        // R6 a correctable read does not fill the log
        flip_read(rnd_addr(), rnd_data(), 1, 5, 0, 0, 1'b0, "R6 no capture on single");

        // R5 random pairs, cleared now and then
        for (int i = 0; i < 200; i++) begin
            q0 = int'($urandom_range(0, NPOS - 1));
            q1 = (q0 + 1 + int'($urandom_range(0, NPOS - 2))) % NPOS;
            flip_read(rnd_addr(), rnd_data(), 2, q0, q1, 0, (i % 17) == 0, "R5 pair flip");
        end

        // R11 three flips: only exclusivity is judged
        for (int i = 0; i < 50; i++) begin
            q0 = int'($urandom_range(0, NPOS - 1));
            q1 = (q0 + 1 + int'($urandom_range(0, NPOS - 2))) % NPOS;
            q2 = q0;
            while (q2 == q0 || q2 == q1) q2 = int'($urandom_range(0, NPOS - 1));
            flip_read(rnd_addr(), rnd_data(), 3, q0, q1, q2, 1'b0, "R11 triple flip");
        end

        step(1'b0, '0, '0, '0, 1'b1, 0, '0, "R9 final clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule